// File: doc/BRIEF.md
# Configurable UART with error status

This block is a full-duplex serial port. Both directions share one frame format. An 8-bit line control input sets that format at run time: the data width, the number of stop bits, and whether a parity bit is sent and of which sense. A 16-bit divisor sets the bit rate. Every bit lasts sixteen ticks of an internal oversample clock, and that clock ticks once every `baudDiv` system clocks.

A host sends a byte with a valid/ready handshake. Received bytes come out on `rxData`, marked by a one-cycle `rxValid` strobe, and stay there until the next byte is delivered. The host pulses `rxTake` when it has used a byte. A byte that completes before the previous one was taken is dropped and counted as an overrun.

Receive faults are kept by type in a sticky status word: parity, framing, overrun and break, plus a summary flag. A pulse on `statusRead` clears the status word. The serial input is synchronised on entry, so the block works in a single clock domain.

Top module: `cfg_uart`

## Requirements
- R1: During and after reset `txLine` is high, `txReady` is 1, `rxValid` is 0 and `errStatus` is 0.
- R2: A transmitted frame is a low start bit, then the data bits least significant first, then the optional parity bit, then high stop bits. The data width is set by `lineCtrl[1:0]`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. `txData` bits above the width are ignored. `lineCtrl[3]`=1 inserts a parity bit. `lineCtrl[4]`=1 makes the parity even (data bits plus parity XOR to 0); `lineCtrl[4]`=0 makes it odd.
- R3: `lineCtrl[2]`=1 sends two stop bits and 0 sends one. `txReady` drops after a byte is accepted (`txValid` and `txReady` both high at a clock edge). It returns after (1 + data bits + parity bit + stop bits) bit periods, less at most one divisor period.
- R4: One bit period is 16 × `baudDiv` clock cycles.
- R5: A received frame yields its data bits assembled least significant first, right-aligned, with the bits above the width equal to 0. `rxValid` pulses for exactly one cycle, and `rxData` does not change except at that pulse.
- R6: A parity bit that does not match the selected sense sets `errStatus[0]`.
- R7: A first stop bit sampled low sets `errStatus[1]`.
- R8: A frame whose data, parity (when enabled) and stop bits are all low sets `errStatus[3]`, together with `errStatus[1]`.
- R9: A frame that completes while the previous byte has not been taken with `rxTake` sets `errStatus[2]`. That frame is discarded: no `rxValid` pulse, and `rxData` keeps the old byte.
- R10: `errStatus[4]` is the OR of bits 3..0. All flags hold until a `statusRead` pulse clears them.
- R11: A low pulse on `rxLine` that is high again at the middle of the start bit starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineCtrl | input | 8 | Frame format: [1:0] width, [2] two stop bits, [3] parity on, [4] even parity |
| baudDiv | input | 16 | Clocks per oversample tick (0 acts as 1) |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte to send is present |
| txReady | output | 1 | Transmitter idle, byte accepted this cycle if valid |
| txLine | output | 1 | Serial output, high when idle |
| rxLine | input | 1 | Serial input (asynchronous) |
| rxData | output | 8 | Last delivered received byte |
| rxValid | output | 1 | One-cycle strobe: new byte on rxData |
| rxTake | input | 1 | Host has consumed the pending received byte |
| statusRead | input | 1 | Clears the error status word |
| errStatus | output | 5 | {any, break, overrun, framing, parity} |

## Verification
The bench goes after five corner cases.

- **Data width.** It uses 5-bit frames with junk in the upper `txData` bits. A transmitter that forgets to mask would put those bits on the line, and a receiver that forgets to right-align would return shifted bytes.
- **Parity.** Parity is checked in both senses, with good and flipped parity bits. An inverted sense would flag correct frames.
- **Break and framing.** An all-zero frame must raise break and framing together. A data-bearing frame with a low stop bit must raise framing alone, which exposes a break detector that ignores the data.
- **Overrun.** The bench leaves a byte unread and sends another. A design that overwrote the held byte, or pulsed `rxValid`, would show a changed `rxData` or an extra strobe.
- **Glitches and timing.** Sticky flags are watched over idle time. A short low glitch must start no frame. Transmit bit timing is measured against the divisor at two settings, which catches off-by-one bit counts and stop-bit miscounts.

// File: rtl/uart_pkg.sv
package uart_pkg;

  localparam int DATA_W = 8;

  // Which level the transmitter drives this cycle
  typedef enum logic [2:0] {
    LINE_MARK,
    LINE_START,
    LINE_DATA,
    LINE_PAR
  } txSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   txLoad;
    logic   txShift;
    txSel_t txSel;
    logic   rxShiftBit;
    logic   rxTakePar;
    logic   rxFinish;
  } ctrlStb_t;

  // Index of the last data bit: width code 0..3 -> 4..7
  function automatic logic [2:0] lastBitIdx(input logic [1:0] lenSel);
    return 3'd4 + {1'b0, lenSel};
  endfunction

  // Number of unused upper bit positions for a width code
  function automatic logic [1:0] padShift(input logic [1:0] lenSel);
    return 2'd3 - lenSel;
  endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   cntNext;

  assign cntNext = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cntNext >= {1'b0, div}) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cntNext[DIV_W-1:0];
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [1:0] lenSel,
  input  logic       twoStop,
  input  logic       parEn,
  input  logic       txValid,
  output logic       txReady,
  input  logic       rxBit,
  output ctrlStb_t   stb
);

  localparam int OVS_W = $clog2(OVS);
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] OVS_MID  = OVS_W'(OVS / 2 - 1);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP1, T_STOP2} txState_t;
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAITHI} rxState_t;

  txState_t         txState;
  rxState_t         rxState;
  logic [OVS_W-1:0] txOvs, rxOvs;
  logic [2:0]       txCnt, rxCnt;
  logic [2:0]       lastIdx;
  logic             txBitEnd, rxSample, rxMidStart;

  assign lastIdx    = lastBitIdx(lenSel);
  assign txBitEnd   = tick && (txOvs == OVS_LAST);
  assign rxSample   = tick && (rxOvs == OVS_LAST);
  assign rxMidStart = tick && (rxOvs == OVS_MID);

  // Transmit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= T_IDLE;
      txOvs   <= '0;
      txCnt   <= '0;
    end else begin
      if (txState == T_IDLE) txOvs <= '0;
      else if (tick)         txOvs <= (txOvs == OVS_LAST) ? '0 : txOvs + 1'b1;
      case (txState)
        T_IDLE:  if (txValid) begin
                   txState <= T_START;
                   txCnt   <= '0;
                 end
        T_START: if (txBitEnd) txState <= T_DATA;
        T_DATA:  if (txBitEnd) begin
                   if (txCnt == lastIdx) txState <= parEn ? T_PAR : T_STOP1;
                   else                  txCnt   <= txCnt + 1'b1;
                 end
        T_PAR:   if (txBitEnd) txState <= T_STOP1;
        T_STOP1: if (txBitEnd) txState <= twoStop ? T_STOP2 : T_IDLE;
        T_STOP2: if (txBitEnd) txState <= T_IDLE;
        default: txState <= T_IDLE;
      endcase
    end
  end

  // Receive sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= R_IDLE;
      rxOvs   <= '0;
      rxCnt   <= '0;
    end else begin
      if (rxState == R_IDLE || rxState == R_WAITHI) rxOvs <= '0;
      else if (tick) begin
        if (rxState == R_START && rxOvs == OVS_MID) rxOvs <= '0;
        else rxOvs <= (rxOvs == OVS_LAST) ? '0 : rxOvs + 1'b1;
      end
      case (rxState)
        R_IDLE:   if (!rxBit) rxState <= R_START;
        R_START:  if (rxMidStart) begin
                    rxState <= rxBit ? R_IDLE : R_DATA;
                    rxCnt   <= '0;
                  end
        R_DATA:   if (rxSample) begin
                    if (rxCnt == lastIdx) rxState <= parEn ? R_PAR : R_STOP;
                    else                  rxCnt   <= rxCnt + 1'b1;
                  end
        R_PAR:    if (rxSample) rxState <= R_STOP;
        R_STOP:   if (rxSample) rxState <= rxBit ? R_IDLE : R_WAITHI;
        R_WAITHI: if (rxBit) rxState <= R_IDLE;
        default:  rxState <= R_IDLE;
      endcase
    end
  end

  assign txReady = (txState == T_IDLE);

  always_comb begin
    stb            = '0;
    stb.txLoad     = (txState == T_IDLE) && txValid;
    stb.txShift    = (txState == T_DATA) && txBitEnd;
    stb.rxShiftBit = (rxState == R_DATA) && rxSample;
    stb.rxTakePar  = (rxState == R_PAR)  && rxSample;
    stb.rxFinish   = (rxState == R_STOP) && rxSample;
    case (txState)
      T_START: stb.txSel = LINE_START;
      T_DATA:  stb.txSel = LINE_DATA;
      T_PAR:   stb.txSel = LINE_PAR;
      default: stb.txSel = LINE_MARK;
    endcase
  end

endmodule

// File: rtl/uart_dp.sv
module uart_dp
  import uart_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        lenSel,
  input  logic              parEn,
  input  logic              parEven,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] txData,
  output logic              txLine,
  input  logic              rxLine,
  output logic              rxBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxTake,
  input  logic              statusRead,
  output logic [4:0]        errStatus
);

  logic [SYNC_STAGES-1:0] rxSync;
  logic [DATA_W-1:0]      txShiftQ, rxShiftQ, txMasked, rxWord;
  logic                   txParQ, rxParQ, pending, pendingLeft;
  logic [3:0]             flags, newErr;
  logic                   parErr, frmErr, brkErr, ovrErr;

  // Input synchroniser, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= '1;
    else       rxSync <= {rxSync[SYNC_STAGES-2:0], rxLine};
  end
  assign rxBit = rxSync[SYNC_STAGES-1];

  // Transmit shifter
  assign txMasked = txData & (8'hFF >> padShift(lenSel));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShiftQ <= '0;
      txParQ   <= 1'b0;
    end else if (stb.txLoad) begin
      txShiftQ <= txMasked;
      txParQ   <= parEven ? ^txMasked : ~^txMasked;
    end else if (stb.txShift) begin
      txShiftQ <= txShiftQ >> 1;
    end
  end

  always_comb begin
    case (stb.txSel)
      LINE_START: txLine = 1'b0;
      LINE_DATA:  txLine = txShiftQ[0];
      LINE_PAR:   txLine = txParQ;
      default:    txLine = 1'b1;
    endcase
  end

  // Receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShiftQ <= '0;
      rxParQ   <= 1'b0;
    end else begin
      if (stb.rxShiftBit) rxShiftQ <= {rxBit, rxShiftQ[DATA_W-1:1]};
      if (stb.rxTakePar)  rxParQ   <= rxBit;
    end
  end

  assign rxWord = rxShiftQ >> padShift(lenSel);

  // Fault classification at the middle of the first stop bit
  assign pendingLeft = pending && !rxTake;
  assign parErr      = parEn && ((^rxWord ^ rxParQ) == parEven);
  assign frmErr      = !rxBit;
  assign brkErr      = !rxBit && (rxWord == '0) && !(parEn && rxParQ);
  assign ovrErr      = pendingLeft;
  assign newErr      = {brkErr, ovrErr, frmErr, parErr} & {4{stb.rxFinish}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      pending <= 1'b0;
      flags   <= '0;
    end else begin
      rxValid <= 1'b0;
      pending <= pendingLeft || stb.rxFinish;
      if (stb.rxFinish && !pendingLeft) begin
        rxData  <= rxWord;
        rxValid <= 1'b1;
      end
      flags <= (statusRead ? 4'b0 : flags) | newErr;
    end
  end

  assign errStatus = {|flags, flags};

endmodule

// File: rtl/cfg_uart.sv
module cfg_uart
  import uart_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        lineCtrl,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txLine,
  input  logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxTake,
  input  logic              statusRead,
  output logic [4:0]        errStatus
);

  ctrlStb_t stb;
  logic     tick, rxBit;
  logic     unusedLcr;

  assign unusedLcr = ^lineCtrl[7:5];

  uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .div(baudDiv), .tick(tick)
  );

  uart_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .lenSel(lineCtrl[1:0]), .twoStop(lineCtrl[2]), .parEn(lineCtrl[3]),
    .txValid(txValid), .txReady(txReady), .rxBit(rxBit), .stb(stb)
  );

  uart_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .lenSel(lineCtrl[1:0]), .parEn(lineCtrl[3]), .parEven(lineCtrl[4]),
    .stb(stb), .txData(txData), .txLine(txLine), .rxLine(rxLine),
    .rxBit(rxBit), .rxData(rxData), .rxValid(rxValid), .rxTake(rxTake),
    .statusRead(statusRead), .errStatus(errStatus)
  );

endmodule

// File: rtl/cfg_uart_chk.sv
module cfg_uart_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txValid,
  input logic       txReady,
  input logic       txLine,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       statusRead,
  input logic [4:0] errStatus
);

  // R1
  tx_idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R3
  tx_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

  // R5
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusRead |=> ((errStatus & $past(errStatus)) == $past(errStatus)));

  // R8
  brk_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    errStatus[3] |-> errStatus[1]);

endmodule

bind cfg_uart cfg_uart_chk u_chk (.*);

// File: tb/cfg_uart_bench.sv
module cfg_uart_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN;
  logic [7:0] lineCtrl;
  logic [15:0] baudDiv;
  logic [7:0] txData;
  logic       txValid, txReady, txLine;
  logic       rxDrive, loopSel, rxLine;
  logic [7:0] rxData;
  logic       rxValid, rxTake, statusRead;
  logic [4:0] errStatus;
  logic       monClr, mainClr;

  assign rxLine     = loopSel ? txLine : rxDrive;
  assign rxTake     = monClr | mainClr;
  assign statusRead = monClr | mainClr;

  cfg_uart u_cfg_uart (
    .clk(clk), .rstN(rstN), .lineCtrl(lineCtrl), .baudDiv(baudDiv),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txLine(txLine),
    .rxLine(rxLine), .rxData(rxData), .rxValid(rxValid), .rxTake(rxTake),
    .statusRead(statusRead), .errStatus(errStatus)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;
  int rxSeen  = 0;
  int div     = 4;
  int bitT    = 64;

  typedef struct {
    logic [7:0] data;
    logic [4:0] stat;
    bit         take;
    string      req;
  } rxItem_t;
  rxItem_t expQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mkLcr(input int n, input bit twoStop, input bit parEn, input bit parEven);
    logic [1:0] w;
    w = 2'(n - 5);
    return {3'b000, parEven, parEn, twoStop, w};
  endfunction

  function automatic logic [4:0] mkStat(input bit par, input bit frm, input bit ovr, input bit brk);
    return {par | frm | ovr | brk, brk, ovr, frm, par};
  endfunction

  function automatic bit parOf(input logic [7:0] w, input int n, input bit parEven);
    bit x = 1'b0;
    for (int i = 0; i < n; i++) x ^= w[i];
    return parEven ? x : ~x;
  endfunction

  task automatic waitBits(input int k);
    repeat (k * bitT) @(negedge clk);
  endtask

  // Scoreboard monitor
  initial begin
    rxItem_t it;
    monClr = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN && rxValid) begin
        rxSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected rxValid", rxData, 0);
        end else begin
          it = expQ.pop_front();
          check(rxData == it.data, {it.req, " data"}, rxData, it.data);
          check(errStatus == it.stat, {it.req, " status"}, errStatus, it.stat);
          if (it.take) begin
            monClr = 1'b1;
            @(negedge clk);
            monClr = 1'b0;
          end
        end
      end
    end
  end

  task automatic pushRx(input logic [7:0] d, input logic [4:0] s, input bit take, input string req);
    rxItem_t it;
    it.data = d; it.stat = s; it.take = take; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic rxFrame(input logic [7:0] w, input int n, input bit parEn, input bit parEven,
                         input bit parFlip, input bit stopBit);
    rxDrive = 1'b0;
    waitBits(1);
    for (int i = 0; i < n; i++) begin
      rxDrive = w[i];
      waitBits(1);
    end
    if (parEn) begin
      rxDrive = parOf(w, n, parEven) ^ parFlip;
      waitBits(1);
    end
    rxDrive = stopBit;
    waitBits(1);
    rxDrive = 1'b1;
    waitBits(1);
  endtask

  task automatic drainQ();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic waitUntil(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic txSend(input logic [7:0] w, input int n, input bit parEn, input bit parEven,
                        input bit twoStop, input string req);
    bit exp[12];
    int tot, cyc0, dur;
    tot = 0;
    exp[tot++] = 1'b0;
    for (int i = 0; i < n; i++) exp[tot++] = w[i];
    if (parEn) exp[tot++] = parOf(w, n, parEven);
    exp[tot++] = 1'b1;
    if (twoStop) exp[tot++] = 1'b1;
    lineCtrl = mkLcr(n, twoStop, parEn, parEven);
    @(negedge clk);
    txData  = w;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    cyc0    = cyc;
    txValid = 1'b0;
    check(txReady == 1'b0, "R3 busy after accept", txReady, 0);
    for (int k = 0; k < tot; k++) begin
      waitUntil(cyc0 + 16 * k * div + 7 * div);
      check(txLine == exp[k], req, txLine, exp[k]);
    end
    while (!txReady) @(negedge clk);
    dur = cyc - cyc0;
    check(dur >= 16 * tot * div - div + 1 && dur <= 16 * tot * div,
          "R3 R4 frame length", dur, 16 * tot * div);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int seen;
    rstN = 1'b0; rxDrive = 1'b1; loopSel = 1'b0; txValid = 1'b0; txData = 8'h00;
    baudDiv = 16'd4; div = 4; bitT = 64; mainClr = 1'b0;
    lineCtrl = mkLcr(8, 0, 0, 0);
    repeat (5) @(negedge clk);
    check(txLine == 1'b1,    "R1 txLine in reset", txLine, 1);
    check(txReady == 1'b1,   "R1 txReady in reset", txReady, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(rxValid == 1'b0,   "R1 rxValid after reset", rxValid, 0);
    check(errStatus == 5'd0, "R1 status after reset", errStatus, 0);

    // Transmit formats
    txSend(8'hA5, 8, 0, 0, 0, "R2 8N1 bit");
    txSend(8'hF3, 5, 1, 1, 0, "R2 5E1 masked bit");
    txSend(8'h3C, 7, 1, 0, 1, "R3 7O2 bit");
    baudDiv = 16'd7; div = 7; bitT = 112;
    repeat (20) @(negedge clk);
    txSend(8'h2D, 6, 0, 0, 1, "R4 6N2 divisor 7 bit");
    baudDiv = 16'd4; div = 4; bitT = 64;
    repeat (20) @(negedge clk);

    // Receive data
    lineCtrl = mkLcr(8, 0, 0, 0);
    pushRx(8'h96, 5'd0, 1, "R5 8N1 rx");
    rxFrame(8'h96, 8, 0, 0, 0, 1);
    drainQ();
    lineCtrl = mkLcr(5, 0, 0, 0);
    pushRx(8'h13, 5'd0, 1, "R5 5-bit rx aligned");
    rxFrame(8'hF3, 5, 0, 0, 0, 1);
    drainQ();

    // Parity
    lineCtrl = mkLcr(7, 0, 1, 1);
    pushRx(8'h55, 5'd0, 1, "R6 even good");
    rxFrame(8'h55, 7, 1, 1, 0, 1);
    drainQ();
    pushRx(8'h55, mkStat(1, 0, 0, 0), 1, "R6 even flipped");
    rxFrame(8'h55, 7, 1, 1, 1, 1);
    drainQ();
    lineCtrl = mkLcr(6, 0, 1, 0);
    pushRx(8'h2B, 5'd0, 1, "R6 odd good");
    rxFrame(8'h2B, 6, 1, 0, 0, 1);
    drainQ();
    pushRx(8'h2B, mkStat(1, 0, 0, 0), 1, "R6 odd flipped");
    rxFrame(8'h2B, 6, 1, 0, 1, 1);
    drainQ();

    // Framing and break
    lineCtrl = mkLcr(8, 0, 0, 0);
    pushRx(8'h5A, mkStat(0, 1, 0, 0), 1, "R7 low stop");
    rxFrame(8'h5A, 8, 0, 0, 0, 0);
    drainQ();
    lineCtrl = mkLcr(8, 0, 1, 1);
    pushRx(8'h00, mkStat(0, 1, 0, 1), 1, "R8 break");
    rxFrame(8'h00, 8, 1, 1, 0, 0);
    drainQ();

    // Overrun
    lineCtrl = mkLcr(8, 0, 0, 0);
    pushRx(8'h11, 5'd0, 0, "R9 first byte held");
    rxFrame(8'h11, 8, 0, 0, 0, 1);
    drainQ();
    seen = rxSeen;
    rxFrame(8'h22, 8, 0, 0, 0, 1);
    repeat (4) @(negedge clk);
    check(errStatus == mkStat(0, 0, 1, 0), "R9 overrun flag", errStatus, mkStat(0, 0, 1, 0));
    check(rxData == 8'h11, "R9 old byte kept", rxData, 8'h11);
    check(rxSeen == seen, "R9 no strobe", rxSeen, seen);
    mainClr = 1'b1;
    @(negedge clk);
    mainClr = 1'b0;
    @(negedge clk);
    check(errStatus == 5'd0, "R10 cleared by read", errStatus, 0);
    pushRx(8'h33, 5'd0, 1, "R9 accepted after take");
    rxFrame(8'h33, 8, 0, 0, 0, 1);
    drainQ();

    // Sticky flags
    lineCtrl = mkLcr(8, 0, 1, 0);
    pushRx(8'h81, mkStat(1, 0, 0, 0), 0, "R10 parity flag");
    rxFrame(8'h81, 8, 1, 0, 1, 1);
    drainQ();
    waitBits(3);
    check(errStatus == mkStat(1, 0, 0, 0), "R10 sticky", errStatus, mkStat(1, 0, 0, 0));
    check(rxData == 8'h81, "R5 rxData held", rxData, 8'h81);
    mainClr = 1'b1;
    @(negedge clk);
    mainClr = 1'b0;
    @(negedge clk);
    check(errStatus == 5'd0, "R10 cleared", errStatus, 0);

    // Start glitch
    lineCtrl = mkLcr(8, 0, 0, 0);
    seen = rxSeen;
    rxDrive = 1'b0;
    repeat (4 * div) @(negedge clk);
    rxDrive = 1'b1;
    waitBits(3);
    check(rxSeen == seen, "R11 glitch ignored", rxSeen, seen);
    check(errStatus == 5'd0, "R11 no error", errStatus, 0);
    pushRx(8'hC7, 5'd0, 1, "R11 frame after glitch");
    rxFrame(8'hC7, 8, 0, 0, 0, 1);
    drainQ();

    // Loopback
    loopSel = 1'b1;
    pushRx(8'h2A, 5'd0, 1, "R2 loopback rx");
    txSend(8'h2A, 6, 1, 0, 1, "R2 loopback tx bit");
    repeat (2 * bitT) @(negedge clk);
    drainQ();
    loopSel = 1'b0;

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule